// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This is a per-core event-counting unit. It holds a parameterised set of general counters and fixed-function counters, all programmed through one register port with a write strobe and a combinational read path. Each general counter has a selector register. The selector picks one line of an event bus, sets the privilege modes the counter runs in, and turns the counter on. The fixed counters each watch a dedicated event pulse and are programmed through one packed control register.

A counter advances only when its local control and its bit in a global enable register are both set. To get a notice after N events, software preloads a counter with minus N, truncated to the counter width. The wrap from all-ones to zero then records a bit in an overflow status register, which is cleared by writing ones to an overflow-clear register. If that counter has its interrupt enabled, the wrap raises a one-cycle interrupt pulse. The interrupt then stays masked until software writes the re-arm register.

Top module: `pmc_unit`

## Requirements
- R1: Address 0x00 reads {width[23:16], general count[15:8], version[7:0]}, and address 0x01 reads {width[12:5], fixed count[4:0]}. Writes to either address have no effect.
- R2: After reset, every selector, the fixed control register (0x05), global enable (0x02), overflow status (0x03), every counter and the interrupt output read zero.
- R3: General counter i (count at 0x20+i, selector at 0x10+i) adds one on each cycle in which all of the following hold:
  - the event bus line named by selector bits [7:0] is high;
  - selector bit 22 (enable) is set;
  - the privilege bit matching the mode input is set: bit 16 when the mode is user, bit 17 when it is kernel.
- R4: Global enable bit i gates general counter i, and bit 32+i gates fixed counter i. Other bits read zero. With the global bit clear, a counter holds its value.
- R5: Fixed counter i (count at 0x30+i) uses control field [4i+3:4i]:
  - bit 0 enables counting in kernel mode;
  - bit 1 enables counting in user mode;
  - bit 2 is the any-thread bit, kept only when VERSION is 3 or more and otherwise read as zero;
  - bit 3 enables the overflow interrupt.
- R6: An increment from all-ones gives zero and sets overflow status bit i for a general counter or bit 32+i for a fixed counter. The status register (0x03) is read-only.
- R7: Writing 0x04 clears each status bit whose written data bit is one. Other status bits are left alone. A new overflow in the same cycle wins over the clear.
- R8: A wrap on a counter with its interrupt enabled gives a one-cycle pulse on irq and then masks the interrupt. The enable is selector bit 20 for a general counter and control bit 3 for a fixed counter. Later wraps raise no pulse until any write to 0x06.
- R9: A register write to a counter in the same cycle as an increment wins. The counter takes the written value and no overflow is flagged.
- R10: Counters read and write as values masked to CW bits, and selectors as 32-bit values. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| evt_bus | input | NEV | Per-cycle event pulses for the general counters |
| evt_fx | input | NFX | Per-cycle event pulse for each fixed counter |
| priv_user | input | 1 | Current privilege mode: 1 = user, 0 = kernel |
| irq | output | 1 | Overflow interrupt pulse |

## Verification
The bench builds the unit with a 12-bit counter width, four event lines, four general and three fixed counters, and VERSION 2. The narrow width keeps preloaded wrap values short and makes the truncation of 64-bit writes plain to see. VERSION 2 exercises the dropping of the any-thread bit. Four general counters fill the low nibble of the global enable register, which shows how it is masked against the upper, fixed-counter half.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DW     = 64;
  localparam int SEL_W  = 32;
  localparam int FX_BASE = 32;

  // selector bit positions
  localparam int SB_USR = 16;
  localparam int SB_OS  = 17;
  localparam int SB_INT = 20;
  localparam int SB_EN  = 22;

  // register addresses
  localparam logic [7:0] A_CAPA  = 8'h00;
  localparam logic [7:0] A_CAPB  = 8'h01;
  localparam logic [7:0] A_GEN   = 8'h02;
  localparam logic [7:0] A_OVS   = 8'h03;
  localparam logic [7:0] A_OVC   = 8'h04;
  localparam logic [7:0] A_FXC   = 8'h05;
  localparam logic [7:0] A_REARM = 8'h06;
  localparam logic [3:0] PG_SEL  = 4'h1;
  localparam logic [3:0] PG_GPC  = 4'h2;
  localparam logic [3:0] PG_FXC  = 4'h3;

  function automatic logic [DW-1:0] gen_mask(input int ngp, input int nfx);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < ngp; i++) m[i] = 1'b1;
    for (int i = 0; i < nfx; i++) m[FX_BASE+i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] fxc_mask(input int nfx, input int ver);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < nfx; i++) begin
      m[4*i]   = 1'b1;
      m[4*i+1] = 1'b1;
      m[4*i+2] = (ver >= 3);
      m[4*i+3] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pmc_gp_slice.sv
module pmc_gp_slice
  import pmc_pkg::*;
#(
  parameter int CW  = 48,
  parameter int NEV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wd,
  input  logic             cnt_we,
  input  logic [CW-1:0]    cnt_wd,
  input  logic             gate,
  input  logic             user,
  input  logic [NEV-1:0]   evt_bus,
  output logic [SEL_W-1:0] sel_q,
  output logic [CW-1:0]    cnt_q,
  output logic             wrap,
  output logic             int_req
);
  logic          hit;
  logic          inc;
  logic          cnt_ce;
  logic [CW-1:0] cnt_d;

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NEV; k++)
      if (sel_q[7:0] == 8'(k)) hit = evt_bus[k];
  end

  assign inc     = hit & gate & sel_q[SB_EN] & (user ? sel_q[SB_USR] : sel_q[SB_OS]);
  assign wrap    = inc & ~cnt_we & (&cnt_q);
  assign int_req = wrap & sel_q[SB_INT];
  assign cnt_ce  = cnt_we | inc;

  always_comb begin
    if (cnt_we) cnt_d = cnt_wd;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= sel_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R4
  gp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !cnt_we) |=> $stable(cnt_q));

  // R9
  gp_wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(cnt_wd)));
endmodule

// File: rtl/pmc_fx_slice.sv
module pmc_fx_slice #(
  parameter int CW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_en,
  input  logic          usr_en,
  input  logic          int_en,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wd,
  input  logic          gate,
  input  logic          user,
  input  logic          evt,
  output logic [CW-1:0] cnt_q,
  output logic          wrap,
  output logic          int_req
);
  logic          inc;
  logic          cnt_ce;
  logic [CW-1:0] cnt_d;

  assign inc     = evt & gate & (user ? usr_en : os_en);
  assign wrap    = inc & ~cnt_we & (&cnt_q);
  assign int_req = wrap & int_en;
  assign cnt_ce  = cnt_we | inc;

  always_comb begin
    if (cnt_we) cnt_d = cnt_wd;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R6
  fx_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
endmodule

// File: rtl/pmc_irq.sv
module pmc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic int_any,
  input  logic rearm,
  output logic irq
);
  logic masked_q, masked_d;
  logic fire;

  assign fire     = int_any & ~masked_q;
  assign masked_d = fire | (masked_q & ~rearm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      masked_q <= 1'b0;
      irq      <= 1'b0;
    end else begin
      masked_q <= masked_d;
      irq      <= fire;
    end
  end

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> masked_q);

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/pmc_unit.sv
module pmc_unit
  import pmc_pkg::*;
#(
  parameter int NGP     = 4,
  parameter int NFX     = 3,
  parameter int CW      = 48,
  parameter int NEV     = 8,
  parameter int VERSION = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [7:0]     reg_addr,
  input  logic [63:0]    reg_wdata,
  output logic [63:0]    reg_rdata,
  input  logic [NEV-1:0] evt_bus,
  input  logic [NFX-1:0] evt_fx,
  input  logic           priv_user,
  output logic           irq
);
  localparam int           FXCW     = 4 * NFX;
  localparam logic [DW-1:0] GEN_MASK = gen_mask(NGP, NFX);
  localparam logic [DW-1:0] FXC_MASK = fxc_mask(NFX, VERSION);

  logic [DW-1:0]   gen_q, ovs_q, ovs_d, wrap_vec;
  logic [FXCW-1:0] fxc_q;
  logic [3:0]      page, idx;
  logic            we_gen, we_fxc, we_ovc, we_rearm;
  logic [NGP-1:0]  gp_wrap, gp_int;
  logic [NFX-1:0]  fx_wrap, fx_int;
  logic [SEL_W-1:0] gp_sel [NGP];
  logic [CW-1:0]   gp_cnt [NGP];
  logic [CW-1:0]   fx_cnt [NFX];

  assign page     = reg_addr[7:4];
  assign idx      = reg_addr[3:0];
  assign we_gen   = reg_we && (reg_addr == A_GEN);
  assign we_fxc   = reg_we && (reg_addr == A_FXC);
  assign we_ovc   = reg_we && (reg_addr == A_OVC);
  assign we_rearm = reg_we && (reg_addr == A_REARM);

  for (genvar g = 0; g < NGP; g++) begin : g_gp
    pmc_gp_slice #(.CW(CW), .NEV(NEV)) i_gp (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_we  (reg_we && page == PG_SEL && idx == 4'(g)),
      .sel_wd  (reg_wdata[SEL_W-1:0]),
      .cnt_we  (reg_we && page == PG_GPC && idx == 4'(g)),
      .cnt_wd  (reg_wdata[CW-1:0]),
      .gate    (gen_q[g]),
      .user    (priv_user),
      .evt_bus (evt_bus),
      .sel_q   (gp_sel[g]),
      .cnt_q   (gp_cnt[g]),
      .wrap    (gp_wrap[g]),
      .int_req (gp_int[g])
    );
  end

  for (genvar f = 0; f < NFX; f++) begin : g_fx
    pmc_fx_slice #(.CW(CW)) i_fx (
      .clk     (clk),
      .rst_n   (rst_n),
      .os_en   (fxc_q[4*f]),
      .usr_en  (fxc_q[4*f+1]),
      .int_en  (fxc_q[4*f+3]),
      .cnt_we  (reg_we && page == PG_FXC && idx == 4'(f)),
      .cnt_wd  (reg_wdata[CW-1:0]),
      .gate    (gen_q[FX_BASE+f]),
      .user    (priv_user),
      .evt     (evt_fx[f]),
      .cnt_q   (fx_cnt[f]),
      .wrap    (fx_wrap[f]),
      .int_req (fx_int[f])
    );
  end

  pmc_irq i_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .int_any ((|gp_int) | (|fx_int)),
    .rearm   (we_rearm),
    .irq     (irq)
  );

  always_comb begin
    wrap_vec = '0;
    for (int g = 0; g < NGP; g++) wrap_vec[g] = gp_wrap[g];
    for (int f = 0; f < NFX; f++) wrap_vec[FX_BASE+f] = fx_wrap[f];
  end

  assign ovs_d = (ovs_q & ~(we_ovc ? reg_wdata : '0)) | wrap_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gen_q <= '0;
    else if (we_gen) gen_q <= reg_wdata & GEN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fxc_q <= '0;
    else if (we_fxc) fxc_q <= reg_wdata[FXCW-1:0] & FXC_MASK[FXCW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovs_q <= '0;
    else        ovs_q <= ovs_d;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CAPA:  reg_rdata[23:0]     = {8'(CW), 8'(NGP), 8'(VERSION)};
      A_CAPB:  reg_rdata[12:0]     = {8'(CW), 5'(NFX)};
      A_GEN:   reg_rdata           = gen_q;
      A_OVS:   reg_rdata           = ovs_q;
      A_FXC:   reg_rdata[FXCW-1:0] = fxc_q;
      default: reg_rdata           = '0;
    endcase
    for (int g = 0; g < NGP; g++) begin
      if (page == PG_SEL && idx == 4'(g)) reg_rdata[SEL_W-1:0] = gp_sel[g];
      if (page == PG_GPC && idx == 4'(g)) reg_rdata[CW-1:0]    = gp_cnt[g];
    end
    for (int f = 0; f < NFX; f++)
      if (page == PG_FXC && idx == 4'(f)) reg_rdata[CW-1:0] = fx_cnt[f];
  end

  for (genvar g = 0; g < NGP; g++) begin : g_chk
    // R6
    ovs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovs_q[g]) |-> $past(gp_wrap[g]));

    // R7
    ovs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_ovc && reg_wdata[g] && !gp_wrap[g]) |=> !ovs_q[g]);
  end
endmodule

// File: tb/test_pmc_unit.sv
module test_pmc_unit;
  localparam int NGP = 4, NFX = 3, CW = 12, NEV = 4, VER = 2;
  localparam logic [63:0] S_EN = 64'h1 << 22, S_USR = 64'h1 << 16,
                          S_OS = 64'h1 << 17, S_INT = 64'h1 << 20;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [7:0]     reg_addr = '0;
  logic [63:0]    reg_wdata = '0;
  logic [63:0]    reg_rdata;
  logic [NEV-1:0] evt_bus = '0;
  logic [NFX-1:0] evt_fx = '0;
  logic           priv_user = 1'b1;
  logic           irq;

  int n_chk = 0, n_bad = 0, irq_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmc_unit #(.NGP(NGP), .NFX(NFX), .CW(CW), .NEV(NEV), .VERSION(VER)) i_pmc_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_bus(evt_bus),
    .evt_fx(evt_fx), .priv_user(priv_user), .irq(irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_seen++;

  localparam int NV = 8;
  localparam logic [7:0]  V_A [NV] = '{8'h02, 8'h05, 8'h10, 8'h21, 8'h32, 8'h00, 8'h01, 8'h03};
  localparam logic [63:0] V_D [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF,
                                      64'hFFFF_FFFF_FFFF_FABC, 64'h1234, 64'h55,
                                      64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_E [NV] = '{64'h0000_0007_0000_000F, 64'hBBB, 64'hFFFF_FFFF,
                                      64'hABC, 64'h234, 64'h0C0402, 64'h183, 64'h0};

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [63:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse_gp(input int line, input int n);
    @(negedge clk); evt_bus[line] = 1'b1;
    repeat (n) @(negedge clk);
    evt_bus[line] = 1'b0;
  endtask

  task automatic pulse_fx(input int line, input int n);
    @(negedge clk); evt_fx[line] = 1'b1;
    repeat (n) @(negedge clk);
    evt_fx[line] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    do_reset();
    // table walk: write then read back (R1, R4, R5, R6, R10)
    for (int v = 0; v < NV; v++) begin
      wr(V_A[v], V_D[v]);
      rd($sformatf("table entry %0d (R1/R4/R5/R6/R10)", v), V_A[v], V_E[v]);
    end
    rd("R10 second read unchanged", 8'h21, 64'hABC);

    do_reset();
    // R2 reset state
    rd("R2 gen", 8'h02, 64'h0);
    rd("R2 fxc", 8'h05, 64'h0);
    rd("R2 ovs", 8'h03, 64'h0);
    rd("R2 sel0", 8'h10, 64'h0);
    rd("R2 gp1", 8'h21, 64'h0);
    rd("R2 fx2", 8'h32, 64'h0);
    chk("R2 irq", {63'h0, irq}, 64'h0);

    // R3 counting with matching code and user mode
    wr(8'h10, S_EN | S_USR | 64'h2);
    wr(8'h02, 64'h1);
    pulse_gp(2, 5);
    rd("R3 count five", 8'h20, 64'd5);
    pulse_gp(1, 3);
    rd("R3 other line ignored", 8'h20, 64'd5);
    priv_user = 1'b0;
    pulse_gp(2, 3);
    rd("R3 kernel mode blocked", 8'h20, 64'd5);
    wr(8'h10, S_EN | S_OS | 64'h2);
    pulse_gp(2, 2);
    rd("R3 kernel mode counts", 8'h20, 64'd7);
    wr(8'h10, S_OS | 64'h2);
    pulse_gp(2, 2);
    rd("R3 local enable clear holds", 8'h20, 64'd7);
    priv_user = 1'b1;

    // R4 global gate
    wr(8'h10, S_EN | S_USR | 64'h2);
    wr(8'h02, 64'h0);
    pulse_gp(2, 4);
    rd("R4 global clear holds", 8'h20, 64'd7);

    // R6 / R8 overflow and interrupt
    wr(8'h10, S_EN | S_USR | S_INT | 64'h2);
    wr(8'h02, 64'h1);
    wr(8'h20, 64'hFFD);
    pulse_gp(2, 3);
    @(negedge clk);
    rd("R6 wrap to zero", 8'h20, 64'h0);
    rd("R6 status bit0", 8'h03, 64'h1);
    chk("R8 first irq", irq_seen, 1);
    wr(8'h20, 64'hFFF);
    pulse_gp(2, 1);
    @(negedge clk);
    chk("R8 masked", irq_seen, 1);
    wr(8'h06, 64'h0);
    wr(8'h20, 64'hFFF);
    pulse_gp(2, 1);
    @(negedge clk);
    chk("R8 rearmed", irq_seen, 2);

    // R7 write-one-to-clear
    wr(8'h04, 64'h2);
    rd("R7 other bit keeps status", 8'h03, 64'h1);
    wr(8'h04, 64'h1);
    rd("R7 cleared", 8'h03, 64'h0);

    // R9 write beats increment, no overflow
    wr(8'h20, 64'hFFF);
    @(negedge clk);
    evt_bus[2] = 1'b1; reg_we = 1'b1; reg_addr = 8'h20; reg_wdata = 64'h5;
    @(negedge clk);
    evt_bus[2] = 1'b0; reg_we = 1'b0;
    rd("R9 written value wins", 8'h20, 64'h5);
    rd("R9 no overflow", 8'h03, 64'h0);

    // R5 fixed counter: field1 = user + interrupt
    wr(8'h06, 64'h0);
    wr(8'h05, 64'hA0);
    wr(8'h02, 64'h1 << 33);
    pulse_fx(1, 4);
    rd("R5 fixed user counts", 8'h31, 64'd4);
    priv_user = 1'b0;
    pulse_fx(1, 3);
    rd("R5 fixed kernel blocked", 8'h31, 64'd4);
    priv_user = 1'b1;
    wr(8'h02, 64'h0);
    pulse_fx(1, 3);
    rd("R4 fixed global clear holds", 8'h31, 64'd4);
    wr(8'h02, 64'h1 << 33);
    wr(8'h31, 64'hFFE);
    pulse_fx(1, 2);
    @(negedge clk);
    rd("R6 fixed wrap", 8'h31, 64'h0);
    rd("R6 status bit33", 8'h03, 64'h1 << 33);
    chk("R8 fixed irq", irq_seen, 3);

    done = 1'b1;
    report();
    $finish;
  end
endmodule